// File: doc/BRIEF.md
# Post-Configuration Startup Sequencer

After the configuration data of a programmable device has been loaded, this block runs a short numbered sequence of phases on a dedicated startup clock. It controls three global events: the release of the hold that keeps every user output in high impedance (GTS), the assertion of the write enable that lets user storage change state (GWE), and the release of the open-drain DONE pad. Each event is tied to a phase number. GWE and GTS can instead wait for the DONE pad, as seen back on its input, to read high. This lets a chain of devices finish together.

A one-cycle configuration-complete strobe starts the sequence. The FSM has five states: `ST_IDLE` waits for the strobe, `ST_STEP` advances the phase, `ST_LOCK_HOLD` waits for clock-manager locks, `ST_DONE_HOLD` waits for a pending DONE-based release, and `ST_FINISHED` is terminal. The transitions are:
- `ST_IDLE -> ST_STEP` when the strobe is accepted.
- `ST_STEP/ST_LOCK_HOLD -> ST_LOCK_HOLD` on a lock stall.
- `ST_STEP/ST_LOCK_HOLD -> ST_DONE_HOLD` at phase 6 while a DONE-based release is pending.
- `ST_STEP/ST_LOCK_HOLD -> ST_FINISHED` after phase 6.
- `ST_STEP/ST_LOCK_HOLD -> ST_STEP` otherwise.
- `ST_DONE_HOLD -> ST_FINISHED` once nothing is pending.

The GWE and GTS choices arrive on 3-bit select inputs and are captured when the strobe is accepted. The lock phase, the DONE phase, the DONE input register and the DONE drive mode are parameters.

Top module: `startup_seq`

## Requirements
- R1: While reset is held and after it is released, `gts`=1, `gwe`=0, `done_oe`=1, `done_o`=0 and `finished`=0. The sequencer is idle.
- R2: The strobe edge is edge 0, and phase 0 starts there. The phase advances by one per clock edge unless stalled, and saturates at 7. `finished` rises after the edge that enters phase 7, which is edge 7 when nothing stalls, and stays high until reset.
- R3: A `gwe_sel` code of 1 to 6 selects the phase k that sets `gwe` to 1. The change is visible after the edge that ends phase k, which is edge k+1 when nothing stalls.
- R4: A `gts_sel` code of 1 to 6 selects the phase that clears `gts`. `gts`=1 means all user outputs are held in high impedance. The release timing is the same as in R3.
- R5: Select code 7 makes that release wait for DONE. It fires on the first edge at which the registered `done_in` reads 1, which is two edges after the pad goes high. With the register stage disabled it fires on the first edge at which `done_in` reads 1.
- R6: Select code 0 keeps the choice already held for that release. After reset the held choice is the parameter default (`GWE_DEF` or `GTS_DEF`).
- R7: When `LCK_PHASE` is 0 to 6 and `LOCK_MASK` is nonzero, the sequencer stays at phase `LCK_PHASE` until every masked `lock_in` bit is 1. A masked bit first read as 1 on edge j (j > `LCK_PHASE`+1) delays later phases by j-`LCK_PHASE`-1 cycles. Unmasked bits have no effect.
- R8: `DONE_PHASE` selects the phase after which the DONE pad stops being driven low. It is then actively driven high (`done_oe`=1, `done_o`=1) when `DRIVE_DONE`=1, or left to float (`done_oe`=0) when `DRIVE_DONE`=0.
- R9: Once `gwe`, `gts` or the DONE pad release has changed, it keeps its new value until reset. The sequencer holds at phase 6 while a DONE-based release is pending, so `finished` implies all three releases are done.
- R10: A strobe that arrives while the sequencer is not idle is ignored and does not shift any release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_end | input | 1 | Configuration-complete strobe |
| gwe_sel | input | 3 | GWE phase code: 0 keep, 1-6 phase, 7 wait DONE |
| gts_sel | input | 3 | GTS phase code: 0 keep, 1-6 phase, 7 wait DONE |
| lock_in | input | N_LOCK | Clock-manager lock flags |
| done_in | input | 1 | DONE pad input |
| gwe | output | 1 | Global write enable |
| gts | output | 1 | Global three-state hold (1 = outputs high impedance) |
| done_o | output | 1 | DONE pad output value |
| done_oe | output | 1 | DONE pad output enable |
| finished | output | 1 | Sequence complete |

## Verification
The checker watches every cycle for the sticky behaviour of GWE, GTS, the DONE pad release and the finished flag. It also checks that finishing is impossible while any release is still outstanding. The exact cycle at which each release happens can only be shown by the bench's scenarios. These cover the chosen phase, the keep code, the lock stall with a masked and an unmasked flag, the DONE wait through the input register with the pad held low from outside, and a strobe that arrives mid-sequence.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    localparam int PHASE_W = 3;

    localparam logic [2:0] SEL_KEEP   = 3'd0;
    localparam logic [2:0] SEL_DONE   = 3'd7;
    localparam logic [2:0] PHASE_LAST = 3'd6;
    localparam logic [2:0] PHASE_END  = 3'd7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_LOCK_HOLD,
        ST_DONE_HOLD,
        ST_FINISHED
    } seq_state_e;

endpackage

// File: rtl/seq_done_stage.sv
module seq_done_stage #(
    parameter bit PIPE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic done_in,
    output logic done_seen
);

    generate
        if (PIPE) begin : g_pipe
            logic done_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    done_q <= 1'b0;
                end else begin
                    done_q <= done_in;
                end
            end
            assign done_seen = done_q;
        end else begin : g_direct
            assign done_seen = done_in;
        end
    endgenerate

endmodule

// File: rtl/seq_release_cell.sv
module seq_release_cell
    import startup_seq_pkg::*;
#(
    parameter logic [2:0] DEF_SEL = 3'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [2:0]         sel_in,
    input  logic               active,
    input  logic [PHASE_W-1:0] phase,
    input  logic               done_seen,
    output logic               fired,
    output logic               pending
);

    logic [2:0] cfg_q;
    logic       fired_q;
    logic       hit;

    always_comb begin
        if (cfg_q == SEL_DONE) begin
            hit = done_seen;
        end else begin
            hit = (cfg_q == phase);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q   <= DEF_SEL;
            fired_q <= 1'b0;
        end else begin
            if (load && (sel_in != SEL_KEEP)) begin
                cfg_q <= sel_in;
            end
            if (active && hit) begin
                fired_q <= 1'b1;
            end
        end
    end

    assign fired   = fired_q;
    assign pending = (cfg_q == SEL_DONE) && !fired_q;

endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
    import startup_seq_pkg::*;
#(
    parameter int                N_LOCK    = 2,
    parameter logic [N_LOCK-1:0] LOCK_MASK = '1,
    parameter logic [2:0]        LCK_PHASE = 3'd7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [N_LOCK-1:0]  lock_in,
    input  logic               done_pending,
    output logic [PHASE_W-1:0] phase,
    output logic               active,
    output logic               accept,
    output logic               finished
);

    localparam bit LOCK_EN = (LCK_PHASE <= PHASE_LAST) && (LOCK_MASK != '0);

    seq_state_e         state_q, state_d;
    logic [PHASE_W-1:0] phase_q, phase_d;
    logic               locks_ok;
    logic               lock_stall;

    assign locks_ok   = &(lock_in | ~LOCK_MASK);
    assign lock_stall = LOCK_EN && (phase_q == LCK_PHASE) && !locks_ok;

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_STEP;
                    phase_d = '0;
                end
            end
            ST_STEP, ST_LOCK_HOLD: begin
                if (lock_stall) begin
                    state_d = ST_LOCK_HOLD;
                end else if (phase_q == PHASE_LAST && done_pending) begin
                    state_d = ST_DONE_HOLD;
                end else if (phase_q == PHASE_LAST) begin
                    state_d = ST_FINISHED;
                    phase_d = PHASE_END;
                end else begin
                    state_d = ST_STEP;
                    phase_d = phase_q + 3'd1;
                end
            end
            ST_DONE_HOLD: begin
                if (!done_pending) begin
                    state_d = ST_FINISHED;
                    phase_d = PHASE_END;
                end
            end
            ST_FINISHED: begin
                state_d = ST_FINISHED;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase    = phase_q;
        accept   = (state_q == ST_IDLE) && start;
        active   = (state_q == ST_STEP) || (state_q == ST_LOCK_HOLD) ||
                   (state_q == ST_DONE_HOLD);
        finished = (state_q == ST_FINISHED);
    end

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_seq_pkg::*;
#(
    parameter int                N_LOCK     = 2,
    parameter logic [N_LOCK-1:0] LOCK_MASK  = '1,
    parameter logic [2:0]        LCK_PHASE  = 3'd7,
    parameter logic [2:0]        GWE_DEF    = 3'd6,
    parameter logic [2:0]        GTS_DEF    = 3'd5,
    parameter logic [2:0]        DONE_PHASE = 3'd4,
    parameter bit                DONE_PIPE  = 1'b0,
    parameter bit                DRIVE_DONE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_end,
    input  logic [2:0]        gwe_sel,
    input  logic [2:0]        gts_sel,
    input  logic [N_LOCK-1:0] lock_in,
    input  logic              done_in,
    output logic              gwe,
    output logic              gts,
    output logic              done_o,
    output logic              done_oe,
    output logic              finished
);

    localparam int         N_REL    = 3;
    localparam int         IX_GWE   = 0;
    localparam int         IX_GTS   = 1;
    localparam int         IX_DONE  = 2;
    localparam logic [8:0] DEF_PACK = {DONE_PHASE, GTS_DEF, GWE_DEF};

    logic [PHASE_W-1:0]      phase;
    logic                    active;
    logic                    accept;
    logic                    done_seen;
    logic                    done_pending;
    logic [N_REL-1:0]        fired;
    logic [N_REL-1:0]        pending;
    logic [N_REL-1:0]        load_vec;
    logic [N_REL-1:0][2:0]   sel_vec;

    assign sel_vec[IX_GWE]   = gwe_sel;
    assign sel_vec[IX_GTS]   = gts_sel;
    assign sel_vec[IX_DONE]  = SEL_KEEP;
    assign load_vec[IX_GWE]  = accept;
    assign load_vec[IX_GTS]  = accept;
    assign load_vec[IX_DONE] = 1'b0;
    assign done_pending      = |pending;

    seq_phase_fsm #(
        .N_LOCK    (N_LOCK),
        .LOCK_MASK (LOCK_MASK),
        .LCK_PHASE (LCK_PHASE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (cfg_end),
        .lock_in      (lock_in),
        .done_pending (done_pending),
        .phase        (phase),
        .active       (active),
        .accept       (accept),
        .finished     (finished)
    );

    seq_done_stage #(
        .PIPE (DONE_PIPE)
    ) u_done_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_in   (done_in),
        .done_seen (done_seen)
    );

    for (genvar i = 0; i < N_REL; i++) begin : g_rel
        seq_release_cell #(
            .DEF_SEL (DEF_PACK[i*3 +: 3])
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_vec[i]),
            .sel_in    (sel_vec[i]),
            .active    (active),
            .phase     (phase),
            .done_seen (done_seen),
            .fired     (fired[i]),
            .pending   (pending[i])
        );
    end

    always_comb begin
        gwe = fired[IX_GWE];
        gts = !fired[IX_GTS];
        if (DRIVE_DONE) begin
            done_oe = 1'b1;
            done_o  = fired[IX_DONE];
        end else begin
            done_oe = !fired[IX_DONE];
            done_o  = 1'b0;
        end
    end

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk #(
    parameter bit DRIVE_DONE = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic gwe,
    input logic gts,
    input logic done_o,
    input logic done_oe,
    input logic finished
);

    logic done_rel;
    assign done_rel = DRIVE_DONE ? (done_oe && done_o) : !done_oe;

    p_gwe_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gwe) |-> gwe);

    p_gts_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gts) |-> !gts);

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done_rel) |-> done_rel);

    p_fin_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(finished) |-> finished);

    p_fin_all_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (gwe && !gts && done_rel));

endmodule

bind startup_seq startup_seq_chk #(
    .DRIVE_DONE (DRIVE_DONE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gwe      (gwe),
    .gts      (gts),
    .done_o   (done_o),
    .done_oe  (done_oe),
    .finished (finished)
);

// File: tb/tb_startup_seq.sv
module tb_startup_seq;

    localparam int K_GTS = 0;
    localparam int K_DONE = 1;
    localparam int K_GWE = 2;
    localparam int K_FIN = 3;

    typedef struct {
        int kind;
        int cyc;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_end = 1'b0;
    logic [2:0] gwe_sel = 3'd0;
    logic [2:0] gts_sel = 3'd0;
    logic [1:0] lock_in = 2'b00;
    logic       ext_low = 1'b0;
    logic       done_pad;
    logic       gwe, gts, done_o, done_oe, finished;

    int   n_chk = 0;
    int   n_bad = 0;
    int   ecnt = 0;
    int   t0 = 0;
    bit   mon_en = 1'b0;
    bit   all_done = 1'b0;
    exp_t expq[$];
    logic [3:0] prev;

    always #10 clk = ~clk;

    assign done_pad = ext_low ? 1'b0 : (done_oe ? done_o : 1'b1);

    startup_seq #(
        .N_LOCK     (2),
        .LOCK_MASK  (2'b01),
        .LCK_PHASE  (3'd4),
        .GWE_DEF    (3'd6),
        .GTS_DEF    (3'd1),
        .DONE_PHASE (3'd2),
        .DONE_PIPE  (1'b1),
        .DRIVE_DONE (1'b1)
    ) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_end  (cfg_end),
        .gwe_sel  (gwe_sel),
        .gts_sel  (gts_sel),
        .lock_in  (lock_in),
        .done_in  (done_pad),
        .gwe      (gwe),
        .gts      (gts),
        .done_o   (done_o),
        .done_oe  (done_oe),
        .finished (finished)
    );

    always @(posedge clk) ecnt <= ecnt + 1;

    function automatic string req_of(int k);
        case (k)
            K_GTS:   return "R4";
            K_DONE:  return "R8";
            K_GWE:   return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected events in (cycle, kind) order as outputs change
    always @(negedge clk) begin
        logic [3:0] cur;
        cur = {finished, gwe, done_o, gts};
        if (mon_en) begin
            for (int k = 0; k < 4; k++) begin
                if (cur[k] != prev[k]) begin
                    if (expq.size() == 0) begin
                        check(1'b0, req_of(k), ecnt - t0, -1);
                    end else begin
                        check(expq[0].kind == k && expq[0].cyc == ecnt - t0,
                              req_of(k), (ecnt - t0) * 10 + k,
                              expq[0].cyc * 10 + expq[0].kind);
                        void'(expq.pop_front());
                    end
                end
            end
        end
        prev = cur;
    end

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // lock_m: rel cycle after which lock[0] rises (-1: high before start)
    // ext_x: rel cycle after which outside hold on DONE is dropped (-1: none)
    // dup_rel: rel cycle of an extra strobe (-1: none)
    task automatic run(input logic [2:0] gs, input logic [2:0] ts,
                       input int lock_m, input int ext_x, input int dup_rel);
        int d, a, r, gsel, tsel, gcyc, tcyc, fcyc, last;
        exp_t items[4];
        mon_en = 1'b0;
        cfg_end = 1'b0;
        lock_in = (lock_m < 0) ? 2'b01 : 2'b00;
        ext_low = (ext_x >= 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check(gts == 1'b1, "R1 gts", gts, 1);
        check(gwe == 1'b0, "R1 gwe", gwe, 0);
        check(done_oe == 1'b1, "R1 done_oe", done_oe, 1);
        check(done_o == 1'b0, "R1 done_o", done_o, 0);
        check(finished == 1'b0, "R1 finished", finished, 0);
        rst_n = 1'b1;
        @(negedge clk);
        d = (lock_m < 0) ? 0 : max2(0, lock_m + 1 - 5);
        gsel = (gs == 3'd0) ? 6 : int'(gs);
        tsel = (ts == 3'd0) ? 1 : int'(ts);
        a = max2(3, ext_x);
        r = a + 2;
        gcyc = (gsel == 7) ? r : gsel + 1 + ((gsel > 4) ? d : 0);
        tcyc = (tsel == 7) ? r : tsel + 1 + ((tsel > 4) ? d : 0);
        fcyc = 7 + d;
        if (gsel == 7 || tsel == 7) fcyc = max2(fcyc, r + 1);
        items[0] = '{K_GTS, tcyc};
        items[1] = '{K_DONE, 3};
        items[2] = '{K_GWE, gcyc};
        items[3] = '{K_FIN, fcyc};
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 3 - i; j++) begin
                if (items[j].cyc * 4 + items[j].kind > items[j+1].cyc * 4 + items[j+1].kind) begin
                    exp_t tmp;
                    tmp = items[j];
                    items[j] = items[j+1];
                    items[j+1] = tmp;
                end
            end
        end
        for (int i = 0; i < 4; i++) expq.push_back(items[i]);
        gwe_sel = gs;
        gts_sel = ts;
        mon_en = 1'b1;
        cfg_end = 1'b1;
        t0 = ecnt + 1;
        @(negedge clk);
        cfg_end = 1'b0;
        last = fcyc + 4;
        for (int rel = 0; rel <= last; rel++) begin
            if (rel == lock_m) lock_in = 2'b01;
            if (rel == ext_x) ext_low = 1'b0;
            cfg_end = (rel == dup_rel);
            @(negedge clk);
        end
        cfg_end = 1'b0;
        check(expq.size() == 0, "R9 missing events", expq.size(), 0);
        expq.delete();
        // R8: drive mode keeps pad actively high after release
        check(done_oe == 1'b1 && done_o == 1'b1, "R8 done drive", {done_oe, done_o}, 3);
        check(finished == 1'b1, "R2 finished held", finished, 1);
    endtask

    initial begin
        prev = 4'b0;
        // R3 R4 R8 R2: plain phases, unmasked lock[1] low has no effect (R7)
        run(3'd5, 3'd3, -1, -1, -1);
        // R6: keep codes use defaults (gwe 6, gts 1)
        run(3'd0, 3'd0, -1, -1, -1);
        // R5 R7: gwe waits for DONE, lock stall delays phase-6 gts
        run(3'd7, 3'd6, 8, -1, -1);
        // R5 R9: gts waits for DONE held low outside until cycle 12
        run(3'd2, 3'd7, -1, 12, -1);
        // R10: a second strobe mid-run is ignored
        run(3'd4, 3'd2, -1, -1, 3);
        all_done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule